// File: doc/BRIEF.md
# Symptom-Triggered Checkpoint Rollback Controller

This controller sits beside a processor pipeline. It decides when an architectural checkpoint is captured and when execution rolls back to one. A checkpoint is captured at a fixed retirement interval, and also whenever an interrupt or a synchronizing memory operation forces one. Two checkpoint slots are kept. The controller only names the slot to write or restore. The storage, the register-map recovery and the store-buffer handling are done elsewhere.

Rollback is triggered by events that hint at a transient fault: an architectural exception, a branch misprediction that the confidence predictor marked as high confidence, or a saturated retirement watchdog. A rollback always goes to the older slot. The controller then reports re-execution until retirement reaches the point where the symptom occurred. If an exception shows up again during that replay, it is passed on as genuine. If an exception-caused replay completes cleanly, a soft-error-detected pulse is raised instead.

A mode input chooses how a symptom is acted on. In immediate mode the rollback happens at once. In deferred mode the rollback waits for the end of the current interval, and all symptoms seen in that interval are merged into one rollback. A suppress input turns symptom-driven rollback off for a while. No pin carries a data stream, so every pin is a plain control or status level or a one-cycle strobe.

Top module: `ckpt_rollback_ctrl`

## Requirements
- R1: While reset is held, every output is 0. On the first clock edge after reset is released, a startup checkpoint into slot 0 is issued. Symptoms sampled on that edge are ignored.
- R2: Every output is a register, updated on the edge that samples the inputs causing it. `ckpt_take_o` pulses on the edge at which the retire count since the last checkpoint or rollback reaches INTERVAL. A retire on that same edge belongs to the interval being closed.
- R3: `irq_i` or `sync_mem_i` forces a checkpoint on the edge it is sampled, whatever the interval count, and restarts the interval count.
- R4: A checkpoint is written to slot 0 when no slot holds a checkpoint. Otherwise it is written to the slot other than the newest, so the two slots alternate and the two most recent checkpoints are always kept.
- R5: `restore_o` names the older slot when two checkpoints are held, and the only one otherwise. `ckpt_take_o` and `restore_o` never pulse together. After a rollback, only the restored slot counts as held.
- R6: An exception outside re-execution, with suppress low, triggers a rollback instead of being reported.
- R7: A misprediction triggers a rollback only when `hiconf_i` is 1. With `hiconf_i` at 0 it has no effect on any output.
- R8: Watchdog saturation triggers a rollback.
- R9: When a symptom and the interval expiry coincide in immediate mode, the rollback wins and no checkpoint is taken on that edge.
- R10: With `defer_mode_i` = 1, symptoms are held pending. Exactly one rollback is issued at the next checkpoint event (interval expiry, irq or sync), in place of that checkpoint. An exception among the merged symptoms makes the rollback count as exception-caused.
- R11: With `suppress_i` = 1, mispredictions and watchdog saturation are ignored, and an exception is reported at once on `exc_genuine_o` with no rollback.
- R12: `reexec_o` rises with `restore_o`. It stays high until the number of retires since the rollback reaches the target. The target is the retires between the older checkpoint and the symptom edge, that edge included. While `reexec_o` is high, symptoms never start another rollback. Interval and forced checkpoints still proceed.
- R13: An exception during re-execution pulses `exc_genuine_o` and ends re-execution. If an exception-caused re-execution reaches its target, `soft_err_o` pulses on the edge `reexec_o` falls. For other causes, no outcome pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| irq_i | input | 1 | Interrupt accepted, forces a checkpoint |
| sync_mem_i | input | 1 | Synchronizing memory operation, forces a checkpoint |
| exc_i | input | 1 | Architectural exception raised |
| mispred_i | input | 1 | Branch misprediction resolved |
| hiconf_i | input | 1 | The mispredicted branch was high confidence |
| wdog_sat_i | input | 1 | Retirement watchdog saturated |
| defer_mode_i | input | 1 | 1: defer rollback to interval end; 0: immediate |
| suppress_i | input | 1 | Disable symptom-driven rollback |
| ckpt_take_o | output | 1 | Capture a checkpoint strobe |
| ckpt_slot_o | output | 1 | Slot to write with the checkpoint |
| restore_o | output | 1 | Roll back strobe |
| restore_slot_o | output | 1 | Slot to restore |
| reexec_o | output | 1 | Re-execution of a rolled-back span in progress |
| exc_genuine_o | output | 1 | Exception passed on for normal handling |
| soft_err_o | output | 1 | Soft error detected and recovered |

## Verification
The stimulus drives a symptom on the very edge the interval expires. A design with the wrong priority would emit a checkpoint, or both strobes at once, instead of a lone rollback. Replay targets are chosen so that re-execution ends on the same edge as an interval checkpoint. This catches a controller that counts the replay against the interval counter, or that ends replay one retire early or late. Symptoms injected during replay expose a nested rollback to a newer slot. An exception injected during replay must report genuine, and a clean exception replay must report soft error; a swapped outcome pulse shows up there. Deferred mode merges an exception with a later misprediction. A design that rolled back twice, picked the newer slot, or forgot the exception cause would emit extra restores or miss the soft-error pulse.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  // pending symptom record used in deferred mode
  typedef struct packed {
    logic hit;   // at least one symptom waiting
    logic exc;   // one of them was an exception
  } pend_t;

  typedef logic slot_t;

  localparam slot_t FIRST_SLOT = 1'b0;
endpackage

// File: rtl/ckpt_interval.sv
module ckpt_interval #(
  parameter int INTERVAL = 16,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire,
  input  logic          clear,
  output logic [CW-1:0] cnt_next,
  output logic          expire
);
  logic [CW-1:0] cnt;

  assign cnt_next = cnt + CW'(retire);
  assign expire   = (cnt_next == CW'(INTERVAL));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt_next;
  end
endmodule

// File: rtl/ckpt_slots.sv
module ckpt_slots
  import ckpt_pkg::*;
#(
  parameter int CW = 5,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          restore,
  input  logic [CW-1:0] cnt_next,
  output logic          have_any,
  output slot_t         take_slot,
  output slot_t         restore_slot,
  output logic [TW-1:0] target
);
  logic [1:0]    held;     // number of live checkpoints, 0..2
  slot_t         newest;
  logic [CW-1:0] span;     // retires between older and newer checkpoint

  assign have_any     = (held != 2'd0);
  assign take_slot    = (held == 2'd0) ? FIRST_SLOT : ~newest;
  assign restore_slot = (held == 2'd2) ? ~newest : newest;
  assign target       = ((held == 2'd2) ? TW'(span) : '0) + TW'(cnt_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 2'd0;
      newest <= FIRST_SLOT;
      span   <= '0;
    end else if (restore) begin
      held   <= 2'd1;
      newest <= restore_slot;
    end else if (take) begin
      held   <= (held == 2'd2) ? 2'd2 : held + 2'd1;
      newest <= take_slot;
      span   <= cnt_next;
    end
  end
endmodule

// File: rtl/ckpt_reexec.sv
module ckpt_reexec #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] target_in,
  input  logic          cause_exc_in,
  input  logic          retire,
  input  logic          exc,
  output logic          active,
  output logic          soft_end
);
  logic [TW-1:0] prog;
  logic [TW-1:0] target;
  logic          cause_exc;
  logic [TW-1:0] prog_next;
  logic          reached;

  assign prog_next = prog + TW'(retire);
  assign reached   = (prog_next >= target);
  assign soft_end  = active && !exc && reached && cause_exc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      prog      <= '0;
      target    <= '0;
      cause_exc <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      prog      <= '0;
      target    <= target_in;
      cause_exc <= cause_exc_in;
    end else if (active) begin
      if (exc || reached) active <= 1'b0;
      else                prog   <= prog_next;
    end
  end
endmodule

// File: rtl/ckpt_rollback_ctrl.sv
module ckpt_rollback_ctrl
  import ckpt_pkg::*;
#(
  parameter int INTERVAL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic retire_i,
  input  logic irq_i,
  input  logic sync_mem_i,
  input  logic exc_i,
  input  logic mispred_i,
  input  logic hiconf_i,
  input  logic wdog_sat_i,
  input  logic defer_mode_i,
  input  logic suppress_i,
  output logic ckpt_take_o,
  output logic ckpt_slot_o,
  output logic restore_o,
  output logic restore_slot_o,
  output logic reexec_o,
  output logic exc_genuine_o,
  output logic soft_err_o
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam int TW = $clog2(2 * INTERVAL + 1);

  logic [CW-1:0] cnt_next;
  logic          expire;
  logic          have_any;
  slot_t         take_slot, restore_slot;
  logic [TW-1:0] target;
  logic          rx_active, rx_soft;
  pend_t         pend, pend_d;

  logic sym, sym_exc, ckpt_evt, restore_now, take_now, genuine;

  // symptom qualification
  always_comb begin
    sym      = have_any && !rx_active && !suppress_i &&
               (exc_i || (mispred_i && hiconf_i) || wdog_sat_i);
    sym_exc  = sym && exc_i;
    ckpt_evt = expire || irq_i || sync_mem_i;
    if (defer_mode_i) restore_now = ckpt_evt && (pend.hit || sym);
    else              restore_now = pend.hit || sym;
    restore_now = restore_now && have_any && !rx_active;
    take_now    = !have_any || (ckpt_evt && !restore_now);
    pend_d.hit  = (pend.hit || sym) && !restore_now;
    pend_d.exc  = (pend.exc || sym_exc) && !restore_now;
    genuine     = have_any && exc_i && (rx_active || suppress_i);
  end

  ckpt_interval #(.INTERVAL(INTERVAL), .CW(CW)) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .retire   (retire_i),
    .clear    (take_now || restore_now),
    .cnt_next (cnt_next),
    .expire   (expire)
  );

  ckpt_slots #(.CW(CW), .TW(TW)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take_now),
    .restore      (restore_now),
    .cnt_next     (cnt_next),
    .have_any     (have_any),
    .take_slot    (take_slot),
    .restore_slot (restore_slot),
    .target       (target)
  );

  ckpt_reexec #(.TW(TW)) u_reexec (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (restore_now),
    .target_in    (target),
    .cause_exc_in (pend.exc || sym_exc),
    .retire       (retire_i),
    .exc          (exc_i),
    .active       (rx_active),
    .soft_end     (rx_soft)
  );

  assign reexec_o = rx_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend           <= '0;
      ckpt_take_o    <= 1'b0;
      ckpt_slot_o    <= 1'b0;
      restore_o      <= 1'b0;
      restore_slot_o <= 1'b0;
      exc_genuine_o  <= 1'b0;
      soft_err_o     <= 1'b0;
    end else begin
      pend           <= pend_d;
      ckpt_take_o    <= take_now;
      ckpt_slot_o    <= take_now ? take_slot : 1'b0;
      restore_o      <= restore_now;
      restore_slot_o <= restore_now ? restore_slot : 1'b0;
      exc_genuine_o  <= genuine;
      soft_err_o     <= rx_soft;
    end
  end
endmodule

// File: rtl/ckpt_rollback_chk.sv
module ckpt_rollback_chk #(
  parameter int INTERVAL = 16
) (
  input logic clk,
  input logic rst_n,
  input logic retire_i,
  input logic ckpt_take_o,
  input logic restore_o,
  input logic reexec_o,
  input logic exc_genuine_o,
  input logic soft_err_o
);
  localparam int CW = $clog2(INTERVAL + 2);
  logic [CW-1:0] seen;

  // retires observed since the last checkpoint or rollback strobe
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (ckpt_take_o || restore_o) seen <= CW'(retire_i);
    else seen <= seen + CW'(retire_i);
  end

  AST_INTERVAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= CW'(INTERVAL)); // R2
  AST_TAKE_XOR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ckpt_take_o && restore_o)); // R5
  AST_NO_NESTED_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> !$past(reexec_o)); // R12
  AST_RESTORE_ENTERS_REEXEC: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> reexec_o); // R12
  AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_genuine_o && soft_err_o)); // R13
  AST_SOFT_ENDS_REEXEC: assert property (@(posedge clk) disable iff (!rst_n)
    soft_err_o |-> (!reexec_o && $past(reexec_o))); // R13
endmodule

bind ckpt_rollback_ctrl ckpt_rollback_chk #(.INTERVAL(INTERVAL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .retire_i      (retire_i),
  .ckpt_take_o   (ckpt_take_o),
  .restore_o     (restore_o),
  .reexec_o      (reexec_o),
  .exc_genuine_o (exc_genuine_o),
  .soft_err_o    (soft_err_o)
);

// File: tb/ckpt_rollback_ctrl_tb.sv
module ckpt_rollback_ctrl_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_i = 0, irq_i = 0, sync_mem_i = 0, exc_i = 0;
  logic mispred_i = 0, hiconf_i = 0, wdog_sat_i = 0;
  logic defer_mode_i = 0, suppress_i = 0;
  logic ckpt_take_o, ckpt_slot_o, restore_o, restore_slot_o;
  logic reexec_o, exc_genuine_o, soft_err_o;

  always #4 clk = ~clk; // 125 MHz

  ckpt_rollback_ctrl #(.INTERVAL(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .irq_i(irq_i),
    .sync_mem_i(sync_mem_i), .exc_i(exc_i), .mispred_i(mispred_i),
    .hiconf_i(hiconf_i), .wdog_sat_i(wdog_sat_i),
    .defer_mode_i(defer_mode_i), .suppress_i(suppress_i),
    .ckpt_take_o(ckpt_take_o), .ckpt_slot_o(ckpt_slot_o),
    .restore_o(restore_o), .restore_slot_o(restore_slot_o),
    .reexec_o(reexec_o), .exc_genuine_o(exc_genuine_o),
    .soft_err_o(soft_err_o)
  );

  // vector: {take, take_slot, restore, restore_slot, genuine, soft, reexec}
  typedef struct {
    logic [6:0] v;
    string      req;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string cur_req = "R1";
  logic  prev_rx = 1'b0;

  function automatic logic [6:0] ev(bit tk, bit ts, bit rs, bit rss,
                                    bit g, bit s, bit rx);
    return {tk, ts, rs, rss, g, s, rx};
  endfunction

  task automatic expect_ev(logic [6:0] v, string req);
    exp_t e;
    e.v = v; e.req = req;
    q.push_back(e);
    cur_req = req;
  endtask

  task automatic step(bit rt, bit iq = 0, bit sy = 0, bit ex = 0,
                      bit mp = 0, bit hc = 0, bit wd = 0);
    @(negedge clk);
    retire_i = rt; irq_i = iq; sync_mem_i = sy; exc_i = ex;
    mispred_i = mp; hiconf_i = hc; wdog_sat_i = wd;
  endtask

  task automatic retire_n(int n);
    for (int i = 0; i < n; i++) step(1);
  endtask

  // monitor: scoreboard pop and compare
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      logic [6:0] obs;
      obs = {ckpt_take_o, ckpt_slot_o, restore_o, restore_slot_o,
             exc_genuine_o, soft_err_o, reexec_o};
      if (ckpt_take_o || restore_o || exc_genuine_o || soft_err_o ||
          reexec_o != prev_rx) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL %s unexpected event: actual %b expected none", cur_req, obs);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (obs !== e.v) begin
            fails++;
            $display("FAIL %s actual %b expected %b", e.req, obs, e.v);
          end
        end
      end
      prev_rx = reexec_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    checks++;
    if ({ckpt_take_o, restore_o, reexec_o, exc_genuine_o, soft_err_o} !== 5'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b expected 00000",
               {ckpt_take_o, restore_o, reexec_o, exc_genuine_o, soft_err_o});
    end
    expect_ev(ev(1,0,0,0,0,0,0), "R1");
    rst_n = 1'b1;
    step(0);

    // R2: interval checkpoint, R4 alternates to slot 1
    expect_ev(ev(1,1,0,0,0,0,0), "R2");
    retire_n(N);
    // R3: forced checkpoint by irq into slot 0
    retire_n(3);
    expect_ev(ev(1,0,0,0,0,0,0), "R3");
    step(0, 1);
    // R6/R5: exception rolls back to older slot 1, target 3+2
    retire_n(2);
    expect_ev(ev(0,0,1,1,0,0,1), "R6");
    step(0, 0, 0, 1);
    // R12: symptoms during replay ignored
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    // R13: clean exception replay -> soft error after 5 retires
    expect_ev(ev(0,0,0,0,0,1,0), "R13");
    retire_n(5);
    // R5: one slot held -> restore it (slot 1), target 6
    expect_ev(ev(0,0,1,1,0,0,1), "R5");
    step(1, 0, 0, 1);
    retire_n(2);
    // R13: recurring exception -> genuine, replay ends
    expect_ev(ev(0,0,0,0,1,0,0), "R13");
    step(0, 0, 0, 1);
    // R7: low-confidence mispredict does nothing
    step(0, 0, 0, 0, 1, 0);
    // R7: high confidence rolls back, target 3
    expect_ev(ev(0,0,1,1,0,0,1), "R7");
    step(1, 0, 0, 0, 1, 1);
    expect_ev(ev(0,0,0,0,0,0,0), "R13");
    retire_n(3);
    // R9/R8: watchdog on expiry edge -> rollback only, target 8
    retire_n(4);
    expect_ev(ev(0,0,1,1,0,0,1), "R9");
    step(1, 0, 0, 0, 0, 0, 1);
    // R12: replay end coincides with interval checkpoint to slot 0
    expect_ev(ev(1,0,0,0,0,0,0), "R12");
    retire_n(N);

    // R10: deferred mode merges exception and mispredict
    defer_mode_i = 1'b1;
    retire_n(2);
    step(0, 0, 0, 1);
    retire_n(1);
    step(0, 0, 0, 0, 1, 1);
    retire_n(4);
    expect_ev(ev(0,0,1,1,0,0,1), "R10");
    retire_n(1);
    // target 16: checkpoint mid replay, then checkpoint + soft error
    expect_ev(ev(1,0,0,0,0,0,1), "R12");
    retire_n(N);
    expect_ev(ev(1,1,0,0,0,1,0), "R10");
    retire_n(N);

    // R11: suppress
    defer_mode_i = 1'b0;
    suppress_i = 1'b1;
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 1);
    expect_ev(ev(0,0,0,0,1,0,0), "R11");
    step(0, 0, 0, 1);
    step(0);
    suppress_i = 1'b0;
    expect_ev(ev(1,0,0,0,0,0,0), "R3");
    step(0, 0, 1);
    step(0);
    repeat (4) step(0);

    while (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      fails++;
      $display("FAIL %s missing event: actual none expected %b", e.req, e.v);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule